// File: doc/BRIEF.md
# Bit-Serial Integer Pairwise Hash

This block computes a keyed universal hash of a message made of unsigned W-bit integer words. Words arrive as pairs, an odd-position word and an even-position word, together with the matching pair of key words. For each pair the block adds the odd message word to the odd key word and the even message word to the even key word, each modulo 2^W. It multiplies the two sums and adds the product into a 2W-bit running total, which wraps modulo 2^(2W). The final total is the hash.

The odd-side sum is formed in one cycle by a parallel ripple-carry adder and held as the multiplicand. The even-side sum is formed one bit per cycle, least significant bit first, by a single full adder with a carry flop. Each of its bits drives one shift-and-add step of a right-shift multiplier. Partial products are added directly onto the running total, which is kept in carry-save form, so there is no separate product register and no separate accumulator. A feedback shift register, modified to pass through all 2^CW states, counts the steps of each multiplication. W must be a power of two between 4 and 256.

A message begins with a `start` strobe, which clears the total. Pairs are then offered through a valid/ready handshake, and the last pair is flagged with `in_last`. After the last multiplication one ripple pass turns the carry-save total into binary, `result` is updated and `done` pulses.

Top module: `pairhash_core`

## Requirements
- R1: `in_ready` is high only while the block is waiting for a pair. A pair is taken on a rising clock edge where `in_valid` and `in_ready` are both high. After `done` the block is idle with `in_ready` low until the next `start`.
- R2: The result equals the sum over all accepted pairs of ((m_odd + k_odd) mod 2^W) × ((m_even + k_even) mod 2^W), taken mod 2^(2W).
- R3: The carry out of each word-level addition is discarded. For example, all-ones plus two gives one, and all-ones plus all-ones gives all-ones minus one.
- R4: A running total that passes 2^(2W) wraps; only the low 2W bits are kept.
- R5: After a pair is accepted that is not flagged last, `in_ready` stays low for exactly W clock cycles and is high again in the cycle after the W-th following edge.
- R6: After the last pair is accepted, `done` goes high W+1 clock edges later, stays high for exactly one cycle, and `result` carries the new hash in that same cycle.
- R7: In the cycle after a `start` strobe, `result` is zero, `done` is low and `in_ready` is high, whatever the block was doing before. An aborted message leaves no trace in the next hash. A message with no pairs leaves the result at zero.
- R8: `result` changes only on a `done` pulse or a `start` strobe. `in_valid` is ignored while `in_ready` is low, so data offered during a multiplication does not enter the hash.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Clears the total and begins a new message |
| in_valid | input | 1 | A word pair and key pair are offered |
| in_ready | output | 1 | The block can accept a pair this cycle |
| in_last | input | 1 | The offered pair is the last of the message |
| m_odd | input | W | Odd-position message word |
| k_odd | input | W | Odd-position key word |
| m_even | input | W | Even-position message word |
| k_even | input | W | Even-position key word |
| done | output | 1 | One-cycle pulse when the hash is ready |
| result | output | 2W | Hash of the last completed message |

## Verification
The assertions assume that `start` is a single-cycle strobe and that `in_valid` and the data words are held steady from the cycle they are offered until the edge that accepts them. The latency checks also assume that no `start` arrives during a pair they are timing. The bench changes inputs only on falling edges, holds each offer until it sees `in_ready` at a falling edge, drops `in_valid` right after the accepting edge, and issues `start` only as one-cycle pulses. Offers made while the block is busy are deliberate and test R8. The expected hashes come from plain 2W-bit integer arithmetic in the bench.

// File: rtl/pairhash_pkg.sv
package pairhash_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_MUL  = 2'd2,
    ST_FOLD = 2'd3
  } ph_state_e;

  // Feedback taps of a maximal-length shift register, one bit per stage,
  // the most significant stage always tapped.
  function automatic logic [7:0] lfsr_taps(input int n);
    case (n)
      2:       return 8'b0000_0011;
      3:       return 8'b0000_0110;
      4:       return 8'b0000_1100;
      5:       return 8'b0001_0100;
      6:       return 8'b0011_0000;
      7:       return 8'b0110_0000;
      default: return 8'b1011_1000;
    endcase
  endfunction

endpackage

// File: rtl/ph_step_lfsr.sv
// Step counter: a shift register with linear feedback, extended so that the
// all-zero state is part of the cycle and the period is exactly 2^CW.
module ph_step_lfsr #(
  parameter int CW = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic adv,
  output logic wrap_o
);
  localparam logic [7:0]    TAPS  = pairhash_pkg::lfsr_taps(CW);
  localparam logic [CW-1:0] MASK  = TAPS[CW-1:0];
  localparam logic [CW-1:0] FINAL = {1'b1, {(CW-1){1'b0}}};

  logic [CW-1:0] st_q, st_d;
  logic          fb;
  logic          st_en;

  always_comb begin
    fb = ^(st_q & MASK);
    if (st_q[CW-2:0] == '0) fb = ~fb;
    st_en = clr | adv;
    st_d  = clr ? '0 : {st_q[CW-2:0], fb};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= '0;
    else if (st_en) st_q <= st_d;
  end

  // Zero is the seed; its predecessor is the final step of a pass.
  assign wrap_o = (st_q == FINAL);

endmodule

// File: rtl/ph_serial_add.sv
// Even-side adder: one full adder and a carry flop, LSB first.
module ph_serial_add #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         adv,
  input  logic [W-1:0] m_in,
  input  logic [W-1:0] k_in,
  output logic         bit_o
);
  logic [W-1:0] m_sr_q, m_sr_d, k_sr_q, k_sr_d;
  logic         cy_q, cy_d;
  logic         sr_en;

  assign bit_o = m_sr_q[0] ^ k_sr_q[0] ^ cy_q;

  always_comb begin
    sr_en = load | adv;
    if (load) begin
      m_sr_d = m_in;
      k_sr_d = k_in;
      cy_d   = 1'b0;
    end else begin
      m_sr_d = {1'b0, m_sr_q[W-1:1]};
      k_sr_d = {1'b0, k_sr_q[W-1:1]};
      cy_d   = (m_sr_q[0] & k_sr_q[0]) | (cy_q & (m_sr_q[0] ^ k_sr_q[0]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sr_q <= '0;
      k_sr_q <= '0;
      cy_q   <= 1'b0;
    end else if (sr_en) begin
      m_sr_q <= m_sr_d;
      k_sr_q <= k_sr_d;
      cy_q   <= cy_d;
    end
  end

endmodule

// File: rtl/ph_csa_row.sv
// One shift-and-add step on a carry-save window. Column i adds the saved
// sum, the saved carry and the partial-product bit; the window then moves
// one place toward the low end, taking a new top bit and releasing its
// lowest sum bit.
module ph_csa_row #(
  parameter int W = 64
) (
  input  logic [W-1:0] s_in,
  input  logic [W-1:0] c_in,
  input  logic [W-1:0] mcand,
  input  logic         mbit,
  input  logic         top_in,
  output logic [W-1:0] s_out,
  output logic [W-1:0] c_out,
  output logic         low_out
);
  logic [W-1:0] col_s;
  logic [W-1:0] col_c;

  for (genvar i = 0; i < W; i++) begin : g_col
    logic pp;
    assign pp       = mcand[i] & mbit;
    assign col_s[i] = s_in[i] ^ c_in[i] ^ pp;
    assign col_c[i] = (s_in[i] & c_in[i]) | (pp & (s_in[i] ^ c_in[i]));
  end

  assign s_out   = {top_in, col_s[W-1:1]};
  assign c_out   = col_c;
  assign low_out = col_s[0];

endmodule

// File: rtl/ph_ripple_add.sv
// Parallel ripple-carry adder, result modulo 2^W.
module ph_ripple_add #(
  parameter int W = 64
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  output logic [W-1:0] sum_o
);
  logic [W-1:0] cy;

  assign cy[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum_o[i] = x_i[i] ^ y_i[i] ^ cy[i];
    if (i < W - 1) begin : g_carry
      assign cy[i+1] = (x_i[i] & y_i[i]) | (cy[i] & (x_i[i] ^ y_i[i]));
    end
  end

endmodule

// File: rtl/pairhash_core.sv
module pairhash_core #(
  parameter int W = 64
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic           in_last,
  input  logic [W-1:0]   m_odd,
  input  logic [W-1:0]   k_odd,
  input  logic [W-1:0]   m_even,
  input  logic [W-1:0]   k_even,
  output logic           done,
  output logic [2*W-1:0] result
);
  import pairhash_pkg::*;

  localparam int CW = $clog2(W);

  ph_state_e      state_q, state_d;
  logic [W-1:0]   mcand_q, mcand_d;
  logic [W-1:0]   sacc_q, sacc_d;
  logic [W-1:0]   cacc_q, cacc_d;
  logic [W-1:0]   half_q, half_d;
  logic           last_q, last_d;
  logic [2*W-1:0] res_q, res_d;
  logic           done_q, done_d;

  logic [W-1:0]   odd_sum;
  logic [W-1:0]   fold_sum;
  logic [W-1:0]   row_s, row_c;
  logic           row_low;
  logic           mbit;
  logic           step_wrap;

  logic           accept, mul_en, fold_en;
  logic           mcand_en, acc_en, res_en;

  assign in_ready = (state_q == ST_WAIT);
  assign accept   = in_ready & in_valid & ~start;
  assign mul_en   = (state_q == ST_MUL) & ~start;
  assign fold_en  = (state_q == ST_FOLD) & ~start;

  ph_ripple_add #(.W(W)) u_odd_add (
    .x_i   (m_odd),
    .y_i   (k_odd),
    .sum_o (odd_sum)
  );

  ph_ripple_add #(.W(W)) u_fold_add (
    .x_i   (sacc_q),
    .y_i   (cacc_q),
    .sum_o (fold_sum)
  );

  ph_serial_add #(.W(W)) u_even_add (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .adv   (mul_en),
    .m_in  (m_even),
    .k_in  (k_even),
    .bit_o (mbit)
  );

  ph_csa_row #(.W(W)) u_row (
    .s_in    (sacc_q),
    .c_in    (cacc_q),
    .mcand   (mcand_q),
    .mbit    (mbit),
    .top_in  (half_q[0]),
    .s_out   (row_s),
    .c_out   (row_c),
    .low_out (row_low)
  );

  ph_step_lfsr #(.CW(CW)) u_steps (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (accept),
    .adv    (mul_en),
    .wrap_o (step_wrap)
  );

  // Sequencing.
  always_comb begin
    state_d = state_q;
    if (start) begin
      state_d = ST_WAIT;
    end else begin
      case (state_q)
        ST_WAIT: if (in_valid) state_d = ST_MUL;
        ST_MUL:  if (step_wrap) state_d = last_q ? ST_FOLD : ST_WAIT;
        ST_FOLD: state_d = ST_IDLE;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  // Datapath next values and clock enables.
  always_comb begin
    mcand_en = accept;
    mcand_d  = odd_sum;
    last_d   = in_last;

    acc_en   = start | accept | mul_en;
    if (start) begin
      sacc_d = '0;
      cacc_d = '0;
      half_d = '0;
    end else if (accept) begin
      // Resolve the high half, swap halves: the low half re-enters the
      // window at weight one, the high half waits to be shifted in at top.
      sacc_d = half_q;
      cacc_d = '0;
      half_d = fold_sum;
    end else begin
      sacc_d = row_s;
      cacc_d = row_c;
      half_d = {row_low, half_q[W-1:1]};
    end

    res_en = start | fold_en;
    res_d  = start ? '0 : {fold_sum, half_q};
    done_d = fold_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q <= '0;
      last_q  <= 1'b0;
    end else if (mcand_en) begin
      mcand_q <= mcand_d;
      last_q  <= last_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sacc_q <= '0;
      cacc_q <= '0;
      half_q <= '0;
    end else if (acc_en) begin
      sacc_q <= sacc_d;
      cacc_q <= cacc_d;
      half_q <= half_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      res_q <= '0;
    else if (res_en) res_q <= res_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done_d;
  end

  assign result = res_q;
  assign done   = done_q;

endmodule

// File: rtl/pairhash_core_chk.sv
module pairhash_core_chk #(
  parameter int W = 64
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           in_valid,
  input logic           in_ready,
  input logic           in_last,
  input logic           done,
  input logic [2*W-1:0] result
);
  logic [15:0] since_q;
  logic        pend_q;
  logic        pend_last_q;
  logic        start_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q     <= '0;
      pend_q      <= 1'b0;
      pend_last_q <= 1'b0;
      start_q     <= 1'b0;
    end else begin
      start_q <= start;
      if (start) begin
        pend_q <= 1'b0;
      end else if (in_valid && in_ready) begin
        pend_q      <= 1'b1;
        pend_last_q <= in_last;
        since_q     <= '0;
      end else if (in_ready || done) begin
        pend_q <= 1'b0;
      end else if (pend_q) begin
        since_q <= since_q + 16'd1;
      end
    end
  end

  // R1: never waiting for a pair while reporting a hash.
  a_r1_ready_excl_done: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !done);

  // R5: a non-final pair keeps the block busy for exactly W cycles.
  a_r5_pair_span: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && in_ready) |-> (since_q == 16'(W) && !pend_last_q));

  // R6: the hash arrives W+1 edges after the final pair.
  a_r6_done_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && done) |-> (since_q == 16'(W + 1) && pend_last_q));

  // R6: the completion pulse lasts a single cycle.
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7: a start strobe clears the total and reopens the input.
  a_r7_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (result == '0 && in_ready && !done));

  // R8: the result only moves on completion or restart.
  a_r8_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && !start_q) |-> $stable(result));

endmodule

bind pairhash_core pairhash_core_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_last  (in_last),
  .done     (done),
  .result   (result)
);

// File: tb/pairhash_core_test.sv
module pairhash_core_test;
  localparam int TW = 64;

  logic            clk;
  logic            rst_n;
  logic            start;
  logic            in_valid;
  logic            in_ready;
  logic            in_last;
  logic [TW-1:0]   m_odd, k_odd, m_even, k_even;
  logic            done;
  logic [2*TW-1:0] result;

  int n_chk = 0;
  int n_err = 0;

  logic [TW-1:0] mo_a [8];
  logic [TW-1:0] ko_a [8];
  logic [TW-1:0] me_a [8];
  logic [TW-1:0] ke_a [8];

  pairhash_core #(.W(TW)) uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_last  (in_last),
    .m_odd    (m_odd),
    .k_odd    (k_odd),
    .m_even   (m_even),
    .k_even   (k_even),
    .done     (done),
    .result   (result)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [TW-1:0] rnd();
    return {$urandom, $urandom};
  endfunction

  function automatic logic [2*TW-1:0] model(input int np);
    logic [2*TW-1:0] acc;
    logic [TW-1:0]   a, b;
    acc = '0;
    for (int p = 0; p < np; p++) begin
      a = mo_a[p] + ko_a[p];
      b = me_a[p] + ke_a[p];
      acc = acc + ({{TW{1'b0}}, a} * {{TW{1'b0}}, b});
    end
    return acc;
  endfunction

  task automatic chk(input string tag, input logic [2*TW-1:0] act,
                     input logic [2*TW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic send_pair(input int p, input logic lst);
    @(negedge clk);
    m_odd = mo_a[p]; k_odd = ko_a[p]; m_even = me_a[p]; k_even = ke_a[p];
    in_last  = lst;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (!in_ready && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (!done && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  // Sends np pairs (a start must precede) and checks span, latency, value.
  task automatic run_msg(input string tag, input int np);
    int n;
    for (int p = 0; p < np; p++) begin
      send_pair(p, p == np - 1);
      if (p < np - 1) begin
        wait_ready(n);
        chk({tag, " R5 busy span"}, 128'(n), 128'(TW));
      end else begin
        wait_done(n);
        chk({tag, " R6 done latency"}, 128'(n), 128'(TW + 1));
      end
    end
    chk({tag, " R2 hash value"}, result, model(np));
    @(negedge clk);
    chk({tag, " R6 single pulse"}, 128'(done), 128'(0));
    chk({tag, " R1 idle after done"}, 128'(in_ready), 128'(0));
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start = 1'b0; in_valid = 1'b0; in_last = 1'b0;
    m_odd = '0; k_odd = '0; m_even = '0; k_even = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset ready", 128'(in_ready), 128'(0));
    chk("R6 reset done", 128'(done), 128'(0));
    chk("R7 reset result", result, '0);
  endtask

  task automatic t_empty();
    pulse_start();
    chk("R7 empty result", result, '0);
    chk("R7 ready after start", 128'(in_ready), 128'(1));
    chk("R7 no done after start", 128'(done), 128'(0));
  endtask

  task automatic t_single();
    mo_a[0] = 64'h0123_4567_89ab_cdef; ko_a[0] = 64'h1111_2222_3333_4444;
    me_a[0] = 64'hfedc_ba98_7654_3210; ke_a[0] = 64'h0f0f_0f0f_0f0f_0f0f;
    pulse_start();
    run_msg("single", 1);
  endtask

  task automatic t_multi();
    for (int p = 0; p < 4; p++) begin
      mo_a[p] = rnd(); ko_a[p] = rnd(); me_a[p] = rnd(); ke_a[p] = rnd();
    end
    pulse_start();
    run_msg("multi4", 4);
  endtask

  task automatic t_word_wrap();
    // R3: all-ones + 2 = 1 and all-ones + all-ones = all-ones - 1.
    mo_a[0] = '1; ko_a[0] = 64'd2; me_a[0] = '1; ke_a[0] = '1;
    mo_a[1] = '1; ko_a[1] = '1;    me_a[1] = 64'h8000_0000_0000_0000;
    ke_a[1] = 64'h8000_0000_0000_0005;
    pulse_start();
    run_msg("R3 word carry", 2);
    chk("R3 explicit value", result,
        128'(64'hffff_ffff_ffff_fffe) + 128'(64'hffff_ffff_ffff_fffe) * 128'd5);
  endtask

  task automatic t_total_wrap();
    // R4: six near-maximal products overflow 2^(2W).
    for (int p = 0; p < 6; p++) begin
      mo_a[p] = '1 - 64'(p); ko_a[p] = '0;
      me_a[p] = '1;          ke_a[p] = '0;
    end
    pulse_start();
    run_msg("R4 total wrap", 6);
  endtask

  task automatic t_abort();
    mo_a[0] = rnd(); ko_a[0] = rnd(); me_a[0] = rnd(); ke_a[0] = rnd();
    pulse_start();
    send_pair(0, 1'b0);
    repeat (10) @(negedge clk);
    pulse_start();
    chk("R7 abort result", result, '0);
    chk("R7 abort ready", 128'(in_ready), 128'(1));
    mo_a[0] = rnd(); ko_a[0] = rnd(); me_a[0] = rnd(); ke_a[0] = rnd();
    run_msg("R7 after abort", 1);
  endtask

  task automatic t_ignore();
    logic [2*TW-1:0] held;
    int n;
    for (int p = 0; p < 2; p++) begin
      mo_a[p] = rnd(); ko_a[p] = rnd(); me_a[p] = rnd(); ke_a[p] = rnd();
    end
    pulse_start();
    send_pair(0, 1'b0);
    // Offer junk while busy; it must not be taken.
    m_odd = '1; k_odd = 64'h5; m_even = '1; k_even = 64'h9; in_last = 1'b1;
    in_valid = 1'b1;
    repeat (20) @(negedge clk);
    chk("R8 busy offer not taken", 128'(in_ready), 128'(0));
    in_valid = 1'b0; in_last = 1'b0;
    wait_ready(n);
    send_pair(1, 1'b1);
    wait_done(n);
    chk("R8 busy offer ignored", result, model(2));
    held = result;
    repeat (25) @(negedge clk);
    chk("R8 result held", result, held);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    t_reset();
    t_empty();
    t_single();
    t_multi();
    t_word_wrap();
    t_total_wrap();
    t_abort();
    t_ignore();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule